// File: doc/BRIEF.md
# Link-Level AckID Retry Engine

This block is the per-port retry engine of a serial packet link. Every packet the port launches carries a 5-bit sequence tag (the ackID) and is kept in a replay store until the far end acknowledges it. On the receive side, the block checks each arriving packet's CRC flag and ackID against the ackID it expects next. It answers each packet with an accept or a not-accept control symbol.

When a packet arrives corrupted, both ends enter a stopped state. The receiver rejects the packet and then discards all traffic. The sender freezes and asks for the receiver's input status with a link-request. The receiver answers with a link-response that names the ackID it expects, and both sides return to normal. The sender then replays its store from exactly that ackID. If the response is lost, the sender repeats the link-request after a programmable timeout.

A port that is not enabled still takes part in link-level acknowledgement, but it delivers only maintenance packets. Software can force both sides back to normal.

Top module: `ackid_retry_port`

## Requirements
- R1: A receive packet with CRC good and ackID equal to the expected value is delivered on `rx_out_*` one cycle later. It is answered one cycle later with an accept symbol (kind 0) carrying its ackID, and the expected ackID increments modulo 32 (starting at 0 after reset).
- R2: In the normal receive state, a packet with a CRC error or an unexpected ackID is not delivered. One cycle later a not-accept symbol (kind 1) carrying the expected ackID is emitted, and `in_err_stop` rises.
- R3: While `in_err_stop` is high, every arriving packet is discarded with no delivery and no symbol, including further errored packets (no second not-accept).
- R4: A link-request on `cs_in` (kind 2) is answered one cycle later with a link-response (kind 3) carrying the expected ackID, and `in_err_stop` falls. A packet arriving in that same cycle is discarded.
- R5: With `port_en` low, a good non-maintenance packet is accepted at link level but not delivered, while a good packet with `rx_in_maint` high is delivered.
- R6: Packets taken on the `tx_in` handshake appear on `tx_out` one cycle later, with ackIDs 0, 1, 2, ... after reset, incrementing modulo 32.
- R7: `tx_in_ready` is low while 31 (`MAX_OUT`) packets are unacknowledged, and nothing new is launched.
- R8: An accept symbol (kind 0) for ackID k releases every stored packet up to and including k.
- R9: A not-accept symbol on `cs_in` raises `out_err_stop` one cycle later. New launches stop, and a link-request (kind 2) appears on `cs_out`.
- R10: While stopped with no link-response, the link-request is reissued exactly `lr_timeout`+2 cycles after the previous one appeared.
- R11: A link-response naming ackID k clears `out_err_stop` one cycle later. The sender replays the stored packets from k onward in order, with their original payloads, before taking any new packet.
- R12: A `force_normal` pulse clears both `in_err_stop` and `out_err_stop` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enabled for non-maintenance traffic |
| lr_timeout | input | TOW | Cycles to wait for a link-response |
| force_normal | input | 1 | Force both sides back to normal |
| tx_in_valid | input | 1 | New packet offered for sending |
| tx_in_data | input | DW | Payload of offered packet |
| tx_in_ready | output | 1 | New packet can be taken |
| tx_out_valid | output | 1 | Packet on the line |
| tx_out_ackid | output | AW | AckID of launched packet |
| tx_out_data | output | DW | Payload of launched packet |
| rx_in_valid | input | 1 | Packet arriving from the line |
| rx_in_ackid | input | AW | AckID of arriving packet |
| rx_in_data | input | DW | Payload of arriving packet |
| rx_in_crc_ok | input | 1 | Arriving packet passed CRC |
| rx_in_maint | input | 1 | Arriving packet is maintenance |
| rx_out_valid | output | 1 | Packet delivered upward |
| rx_out_data | output | DW | Delivered payload |
| cs_in_valid | input | 1 | Control symbol received |
| cs_in_kind | input | 2 | 0 accept, 1 not-accept, 2 link-request, 3 link-response |
| cs_in_ackid | input | AW | AckID carried by received symbol |
| cs_out_valid | output | 1 | Control symbol to send |
| cs_out_kind | output | 2 | Kind of symbol to send, same encoding |
| cs_out_ackid | output | AW | AckID carried by symbol to send |
| in_err_stop | output | 1 | Receiver in input-error-stopped state |
| out_err_stop | output | 1 | Sender in output-error-stopped state |

## Verification
A wrong expected ackID inside the receiver shows up at the ports on the next packet. That packet draws a not-accept where an accept was due, or an accept naming the wrong ackID, one cycle after it arrives. A corrupted replay pointer or release pointer in the sender shows up in two ways. One is a wrong ackID or payload in the first replayed packet, one cycle after the link-response. The other is `tx_in_ready` dropping early or late against the count of unacknowledged packets. A stuck stopped flag appears at once on `in_err_stop` or `out_err_stop`, and as missing or repeated link-requests within `lr_timeout`+2 cycles.

// File: rtl/ackid_pkg.sv
package ackid_pkg;
   // Control-symbol kinds; the encoding is visible on the ports.
   typedef enum logic [1:0] {
      CS_ACCEPT     = 2'd0,
      CS_NOT_ACCEPT = 2'd1,
      CS_LINK_REQ   = 2'd2,
      CS_LINK_RESP  = 2'd3
   } cs_kind_e;
endpackage

// File: rtl/ackid_rx_guard.sv
module ackid_rx_guard
   import ackid_pkg::*;
#(
   parameter int AW = 5,
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          port_en,
   input  logic          force_normal,
   input  logic          lreq_in,
   input  logic          rx_in_valid,
   input  logic [AW-1:0] rx_in_ackid,
   input  logic [DW-1:0] rx_in_data,
   input  logic          rx_in_crc_ok,
   input  logic          rx_in_maint,
   output logic          rx_out_valid,
   output logic [DW-1:0] rx_out_data,
   output logic          sym_valid,
   output logic [1:0]    sym_kind,
   output logic [AW-1:0] sym_ackid,
   output logic          stopped
);
   logic          stop_q;
   logic [AW-1:0] expect_q;
   logic          pkt_good;
   logic          pkt_bad;

   assign pkt_good = rx_in_valid && rx_in_crc_ok && (rx_in_ackid == expect_q);
   assign pkt_bad  = rx_in_valid && !(rx_in_crc_ok && (rx_in_ackid == expect_q));
   assign stopped  = stop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q       <= 1'b0;
         expect_q     <= '0;
         rx_out_valid <= 1'b0;
         rx_out_data  <= '0;
         sym_valid    <= 1'b0;
         sym_kind     <= CS_ACCEPT;
         sym_ackid    <= '0;
      end else begin
         rx_out_valid <= 1'b0;
         sym_valid    <= 1'b0;
         if (lreq_in) begin
            // status query wins; any packet this cycle is dropped
            sym_valid <= 1'b1;
            sym_kind  <= CS_LINK_RESP;
            sym_ackid <= expect_q;
            stop_q    <= 1'b0;
         end else if (!stop_q) begin
            if (pkt_good) begin
               sym_valid    <= 1'b1;
               sym_kind     <= CS_ACCEPT;
               sym_ackid    <= rx_in_ackid;
               expect_q     <= expect_q + 1'b1;
               rx_out_valid <= port_en || rx_in_maint;
               rx_out_data  <= rx_in_data;
            end else if (pkt_bad) begin
               sym_valid <= 1'b1;
               sym_kind  <= CS_NOT_ACCEPT;
               sym_ackid <= expect_q;
               stop_q    <= 1'b1;
            end
         end
         if (force_normal) stop_q <= 1'b0;
      end
   end

   assert_discard_when_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && rx_in_valid && !lreq_in) |=> (!rx_out_valid && !sym_valid));

   assert_enter_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_q && pkt_bad && !lreq_in && !force_normal) |=>
         (stop_q && sym_valid && sym_kind == CS_NOT_ACCEPT && !rx_out_valid));

   assert_resp_leaves_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lreq_in |=> (!stop_q && sym_valid && sym_kind == CS_LINK_RESP));
endmodule

// File: rtl/ackid_tx_replay.sv
module ackid_tx_replay
   import ackid_pkg::*;
#(
   parameter int AW      = 5,
   parameter int DW      = 32,
   parameter int MAX_OUT = 31,
   parameter int TOW     = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           force_normal,
   input  logic [TOW-1:0] lr_timeout,
   input  logic           tx_in_valid,
   input  logic [DW-1:0]  tx_in_data,
   output logic           tx_in_ready,
   output logic           tx_out_valid,
   output logic [AW-1:0]  tx_out_ackid,
   output logic [DW-1:0]  tx_out_data,
   input  logic           cs_in_valid,
   input  logic [1:0]     cs_in_kind,
   input  logic [AW-1:0]  cs_in_ackid,
   input  logic           lr_grant,
   output logic           lr_req,
   output logic           stopped
);
   localparam int         SLOTS = 1 << AW;
   localparam logic [AW:0] MAX_W = (AW + 1)'(MAX_OUT);

   logic [AW-1:0]  ack_q, send_q, next_q;
   logic           stop_q, lr_q;
   logic [TOW-1:0] tmr_q;
   logic [DW-1:0]  slot_bus [SLOTS];

   logic [AW-1:0] outstanding, in_flight, sym_off;
   logic          replaying, push, replay_go;
   logic          acc_hit, na_hit, resp_hit;

   assign outstanding = next_q - ack_q;
   assign in_flight   = send_q - ack_q;
   assign sym_off     = cs_in_ackid - ack_q;
   assign replaying   = (send_q != next_q);
   assign tx_in_ready = !stop_q && !replaying && ({1'b0, outstanding} < MAX_W);
   assign push        = tx_in_valid && tx_in_ready;
   assign replay_go   = !stop_q && replaying;

   assign acc_hit  = cs_in_valid && (cs_in_kind == CS_ACCEPT) && (sym_off < in_flight);
   assign na_hit   = cs_in_valid && (cs_in_kind == CS_NOT_ACCEPT) && !stop_q;
   assign resp_hit = cs_in_valid && (cs_in_kind == CS_LINK_RESP) && stop_q
                     && (sym_off <= outstanding);

   assign lr_req  = lr_q;
   assign stopped = stop_q;

   // Replay store: one register per ackID value.
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [DW-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                         slot_q <= '0;
         else if (push && next_q == AW'(s))  slot_q <= tx_in_data;
      end
      assign slot_bus[s] = slot_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q        <= '0;
         send_q       <= '0;
         next_q       <= '0;
         stop_q       <= 1'b0;
         lr_q         <= 1'b0;
         tmr_q        <= '0;
         tx_out_valid <= 1'b0;
         tx_out_ackid <= '0;
         tx_out_data  <= '0;
      end else begin
         tx_out_valid <= 1'b0;
         if (push) begin
            tx_out_valid <= 1'b1;
            tx_out_ackid <= next_q;
            tx_out_data  <= tx_in_data;
            next_q       <= next_q + 1'b1;
            send_q       <= send_q + 1'b1;
         end else if (replay_go) begin
            tx_out_valid <= 1'b1;
            tx_out_ackid <= send_q;
            tx_out_data  <= slot_bus[send_q];
            send_q       <= send_q + 1'b1;
         end

         if (acc_hit) ack_q <= cs_in_ackid + 1'b1;

         if (stop_q && !resp_hit) begin
            if (lr_q) begin
               if (lr_grant) begin
                  lr_q  <= 1'b0;
                  tmr_q <= '0;
               end
            end else if (tmr_q >= lr_timeout) begin
               lr_q <= 1'b1;
            end else begin
               tmr_q <= tmr_q + 1'b1;
            end
         end

         if (resp_hit) begin
            ack_q  <= cs_in_ackid;
            send_q <= cs_in_ackid;
            stop_q <= 1'b0;
            lr_q   <= 1'b0;
         end
         if (na_hit) begin
            stop_q <= 1'b1;
            lr_q   <= 1'b1;
            tmr_q  <= '0;
         end
         if (force_normal) begin
            stop_q <= 1'b0;
            lr_q   <= 1'b0;
         end
      end
   end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, outstanding} <= MAX_W));

   assert_quiet_when_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_q && !resp_hit && !force_normal) |=> !tx_out_valid);

   assert_request_on_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (na_hit && !force_normal) |=> (stop_q && lr_q));
endmodule

// File: rtl/ackid_cs_merge.sv
module ackid_cs_merge
   import ackid_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic          rx_sym_valid,
   input  logic [1:0]    rx_sym_kind,
   input  logic [AW-1:0] rx_sym_ackid,
   input  logic          lr_req,
   output logic          lr_grant,
   output logic          cs_out_valid,
   output logic [1:0]    cs_out_kind,
   output logic [AW-1:0] cs_out_ackid
);
   // Receiver answers go first; a link-request waits for a free slot.
   assign lr_grant     = lr_req && !rx_sym_valid;
   assign cs_out_valid = rx_sym_valid || lr_req;
   assign cs_out_kind  = rx_sym_valid ? rx_sym_kind : CS_LINK_REQ;
   assign cs_out_ackid = rx_sym_valid ? rx_sym_ackid : '0;
endmodule

// File: rtl/ackid_retry_port.sv
module ackid_retry_port
   import ackid_pkg::*;
#(
   parameter int AW      = 5,
   parameter int DW      = 32,
   parameter int MAX_OUT = 31,
   parameter int TOW     = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           port_en,
   input  logic [TOW-1:0] lr_timeout,
   input  logic           force_normal,
   input  logic           tx_in_valid,
   input  logic [DW-1:0]  tx_in_data,
   output logic           tx_in_ready,
   output logic           tx_out_valid,
   output logic [AW-1:0]  tx_out_ackid,
   output logic [DW-1:0]  tx_out_data,
   input  logic           rx_in_valid,
   input  logic [AW-1:0]  rx_in_ackid,
   input  logic [DW-1:0]  rx_in_data,
   input  logic           rx_in_crc_ok,
   input  logic           rx_in_maint,
   output logic           rx_out_valid,
   output logic [DW-1:0]  rx_out_data,
   input  logic           cs_in_valid,
   input  logic [1:0]     cs_in_kind,
   input  logic [AW-1:0]  cs_in_ackid,
   output logic           cs_out_valid,
   output logic [1:0]     cs_out_kind,
   output logic [AW-1:0]  cs_out_ackid,
   output logic           in_err_stop,
   output logic           out_err_stop
);
   if (AW < 2 || AW > 8) begin : g_bad_aw
      $error("AW must lie in 2..8");
   end
   if (MAX_OUT < 1 || MAX_OUT > (1 << AW) - 1) begin : g_bad_max
      $error("MAX_OUT must lie in 1..2**AW-1");
   end
   if (DW < 1 || TOW < 1) begin : g_bad_w
      $error("DW and TOW must be positive");
   end

   logic          rx_sym_valid;
   logic [1:0]    rx_sym_kind;
   logic [AW-1:0] rx_sym_ackid;
   logic          lr_req, lr_grant;
   logic          lreq_in;

   assign lreq_in = cs_in_valid && (cs_in_kind == CS_LINK_REQ);

   ackid_rx_guard #(.AW(AW), .DW(DW)) u_rx (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .force_normal(force_normal),
      .lreq_in(lreq_in), .rx_in_valid(rx_in_valid), .rx_in_ackid(rx_in_ackid),
      .rx_in_data(rx_in_data), .rx_in_crc_ok(rx_in_crc_ok), .rx_in_maint(rx_in_maint),
      .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
      .sym_valid(rx_sym_valid), .sym_kind(rx_sym_kind), .sym_ackid(rx_sym_ackid),
      .stopped(in_err_stop)
   );

   ackid_tx_replay #(.AW(AW), .DW(DW), .MAX_OUT(MAX_OUT), .TOW(TOW)) u_tx (
      .clk(clk), .rst_n(rst_n), .force_normal(force_normal), .lr_timeout(lr_timeout),
      .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data), .tx_in_ready(tx_in_ready),
      .tx_out_valid(tx_out_valid), .tx_out_ackid(tx_out_ackid), .tx_out_data(tx_out_data),
      .cs_in_valid(cs_in_valid), .cs_in_kind(cs_in_kind), .cs_in_ackid(cs_in_ackid),
      .lr_grant(lr_grant), .lr_req(lr_req), .stopped(out_err_stop)
   );

   ackid_cs_merge #(.AW(AW)) u_merge (
      .rx_sym_valid(rx_sym_valid), .rx_sym_kind(rx_sym_kind), .rx_sym_ackid(rx_sym_ackid),
      .lr_req(lr_req), .lr_grant(lr_grant),
      .cs_out_valid(cs_out_valid), .cs_out_kind(cs_out_kind), .cs_out_ackid(cs_out_ackid)
   );

   assert_force_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
      force_normal |=> (!in_err_stop && !out_err_stop));

   assert_request_only_stopped_R10: assert property (@(posedge clk) disable iff (!rst_n)
      lr_grant |-> out_err_stop);
endmodule

// File: tb/ackid_retry_port_bench.sv
module ackid_retry_port_bench;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int TO = 5;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic           rst_n, port_en, force_normal;
   logic [15:0]    lr_timeout;
   logic           tx_in_valid, tx_in_ready, tx_out_valid;
   logic [DW-1:0]  tx_in_data, tx_out_data;
   logic [AW-1:0]  tx_out_ackid;
   logic           rx_in_valid, rx_in_crc_ok, rx_in_maint, rx_out_valid;
   logic [AW-1:0]  rx_in_ackid;
   logic [DW-1:0]  rx_in_data, rx_out_data;
   logic           cs_in_valid, cs_out_valid;
   logic [1:0]     cs_in_kind, cs_out_kind;
   logic [AW-1:0]  cs_in_ackid, cs_out_ackid;
   logic           in_err_stop, out_err_stop;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] sent_data [32];

   ackid_retry_port u_ackid_retry_port (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .lr_timeout(lr_timeout),
      .force_normal(force_normal), .tx_in_valid(tx_in_valid), .tx_in_data(tx_in_data),
      .tx_in_ready(tx_in_ready), .tx_out_valid(tx_out_valid), .tx_out_ackid(tx_out_ackid),
      .tx_out_data(tx_out_data), .rx_in_valid(rx_in_valid), .rx_in_ackid(rx_in_ackid),
      .rx_in_data(rx_in_data), .rx_in_crc_ok(rx_in_crc_ok), .rx_in_maint(rx_in_maint),
      .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data), .cs_in_valid(cs_in_valid),
      .cs_in_kind(cs_in_kind), .cs_in_ackid(cs_in_ackid), .cs_out_valid(cs_out_valid),
      .cs_out_kind(cs_out_kind), .cs_out_ackid(cs_out_ackid),
      .in_err_stop(in_err_stop), .out_err_stop(out_err_stop)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic rx_pkt(input logic [AW-1:0] id, input logic [DW-1:0] d,
                         input logic ok, input logic maint);
      rx_in_valid = 1'b1; rx_in_ackid = id; rx_in_data = d;
      rx_in_crc_ok = ok; rx_in_maint = maint;
      step();
      rx_in_valid = 1'b0; rx_in_maint = 1'b0;
   endtask

   task automatic cs_send(input logic [1:0] kind, input logic [AW-1:0] id);
      cs_in_valid = 1'b1; cs_in_kind = kind; cs_in_ackid = id;
      step();
      cs_in_valid = 1'b0;
   endtask

   task automatic expect_sym(input string req, input logic [1:0] kind, input logic [AW-1:0] id);
      check(req, "cs_out_valid", 32'(cs_out_valid), 32'd1);
      check(req, "cs_out_kind", 32'(cs_out_kind), 32'(kind));
      check(req, "cs_out_ackid", 32'(cs_out_ackid), 32'(id));
   endtask

   task automatic t_reset();
      check("R6", "reset tx_out_valid", 32'(tx_out_valid), 32'd0);
      check("R6", "reset tx_in_ready", 32'(tx_in_ready), 32'd1);
      check("R2", "reset in_err_stop", 32'(in_err_stop), 32'd0);
      check("R9", "reset out_err_stop", 32'(out_err_stop), 32'd0);
      check("R1", "reset cs_out_valid", 32'(cs_out_valid), 32'd0);
   endtask

   task automatic t_rx_recovery();
      rx_pkt(5'd0, 32'h1111_0000, 1'b1, 1'b0);               // R1
      check("R1", "rx_out_valid", 32'(rx_out_valid), 32'd1);
      check("R1", "rx_out_data", rx_out_data, 32'h1111_0000);
      expect_sym("R1", 2'd0, 5'd0);
      rx_pkt(5'd1, 32'h1111_0001, 1'b0, 1'b0);               // R2 CRC error
      check("R2", "rx_out_valid", 32'(rx_out_valid), 32'd0);
      check("R2", "in_err_stop", 32'(in_err_stop), 32'd1);
      expect_sym("R2", 2'd1, 5'd1);
      rx_pkt(5'd1, 32'h1111_0002, 1'b1, 1'b0);               // R3 good but stopped
      check("R3", "rx_out_valid", 32'(rx_out_valid), 32'd0);
      check("R3", "cs_out_valid", 32'(cs_out_valid), 32'd0);
      rx_pkt(5'd1, 32'h1111_0003, 1'b0, 1'b0);               // R3 no second not-accept
      check("R3", "cs_out_valid", 32'(cs_out_valid), 32'd0);
      check("R3", "in_err_stop", 32'(in_err_stop), 32'd1);
      cs_send(2'd2, 5'd0);                                   // R4
      expect_sym("R4", 2'd3, 5'd1);
      check("R4", "in_err_stop", 32'(in_err_stop), 32'd0);
      rx_pkt(5'd1, 32'h1111_0004, 1'b1, 1'b0);
      expect_sym("R4", 2'd0, 5'd1);
      check("R4", "rx_out_data", rx_out_data, 32'h1111_0004);
      rx_pkt(5'd5, 32'h1111_0005, 1'b1, 1'b0);               // R2 wrong ackID
      expect_sym("R2", 2'd1, 5'd2);
      check("R2", "rx_out_valid", 32'(rx_out_valid), 32'd0);
      cs_send(2'd2, 5'd0);
      expect_sym("R4", 2'd3, 5'd2);
   endtask

   task automatic t_rx_disabled();
      port_en = 1'b0;
      rx_pkt(5'd2, 32'h2222_0000, 1'b1, 1'b0);               // R5 dropped
      check("R5", "rx_out_valid", 32'(rx_out_valid), 32'd0);
      expect_sym("R5", 2'd0, 5'd2);
      rx_pkt(5'd3, 32'h2222_0001, 1'b1, 1'b1);               // R5 maintenance
      check("R5", "rx_out_valid maint", 32'(rx_out_valid), 32'd1);
      check("R5", "rx_out_data maint", rx_out_data, 32'h2222_0001);
      port_en = 1'b1;
   endtask

   task automatic push_and_check(input string req, input int n, input int first_id,
                                 input int tag);
      for (int i = 0; i < n; i++) begin
         logic [AW-1:0] id;
         id = AW'(first_id + i);
         tx_in_valid = 1'b1;
         tx_in_data  = 32'hC0DE_0000 + 32'(tag + i);
         sent_data[id] = tx_in_data;
         step();
         check(req, "tx_out_valid", 32'(tx_out_valid), 32'd1);
         check(req, "tx_out_ackid", 32'(tx_out_ackid), 32'(id));
         check(req, "tx_out_data", tx_out_data, sent_data[id]);
      end
      tx_in_valid = 1'b0;
   endtask

   task automatic t_tx_fill();
      push_and_check("R6", 3, 0, 0);
      cs_send(2'd0, 5'd1);                                   // R8 releases 0 and 1
      push_and_check("R7", 30, 3, 100);                      // 31 outstanding: 2..0
      check("R7", "tx_in_ready at limit", 32'(tx_in_ready), 32'd0);
      tx_in_valid = 1'b1; tx_in_data = 32'hDEAD_BEEF;
      step();
      check("R7", "no launch at limit", 32'(tx_out_valid), 32'd0);
      tx_in_valid = 1'b0;
      cs_send(2'd0, 5'd2);                                   // R8 release one
      check("R8", "tx_in_ready after accept", 32'(tx_in_ready), 32'd1);
   endtask

   task automatic t_tx_recovery();
      int gap;
      cs_send(2'd1, 5'd3);                                   // R9
      check("R9", "out_err_stop", 32'(out_err_stop), 32'd1);
      check("R9", "tx_in_ready", 32'(tx_in_ready), 32'd0);
      expect_sym("R9", 2'd2, 5'd0);
      tx_in_valid = 1'b1; tx_in_data = 32'hBAD0_0001;
      gap = 0;
      for (int k = 0; k < 40; k++) begin
         step();
         gap++;
         if (k == 0) check("R9", "no launch stopped", 32'(tx_out_valid), 32'd0);
         tx_in_valid = 1'b0;
         if (cs_out_valid && cs_out_kind == 2'd2) break;
      end
      check("R10", "link-request gap", 32'(gap), 32'(TO + 2));
      cs_send(2'd3, 5'd3);                                   // R11
      check("R11", "out_err_stop", 32'(out_err_stop), 32'd0);
      for (int i = 0; i < 30; i++) begin
         logic [AW-1:0] id;
         id = AW'(3 + i);
         step();
         check("R11", "replay valid", 32'(tx_out_valid), 32'd1);
         check("R11", "replay ackid", 32'(tx_out_ackid), 32'(id));
         check("R11", "replay data", tx_out_data, sent_data[id]);
      end
      step();
      check("R11", "replay ends", 32'(tx_out_valid), 32'd0);
   endtask

   task automatic t_force();
      cs_send(2'd0, 5'd0);                                   // drain store
      cs_send(2'd1, 5'd1);
      rx_pkt(5'd9, 32'h3333_0000, 1'b0, 1'b0);
      check("R12", "in_err_stop set", 32'(in_err_stop), 32'd1);
      check("R12", "out_err_stop set", 32'(out_err_stop), 32'd1);
      force_normal = 1'b1;
      step();
      force_normal = 1'b0;
      check("R12", "in_err_stop cleared", 32'(in_err_stop), 32'd0);
      check("R12", "out_err_stop cleared", 32'(out_err_stop), 32'd0);
      check("R12", "tx_in_ready", 32'(tx_in_ready), 32'd1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; port_en = 1'b1; force_normal = 1'b0; lr_timeout = 16'(TO);
      tx_in_valid = 1'b0; tx_in_data = '0;
      rx_in_valid = 1'b0; rx_in_ackid = '0; rx_in_data = '0;
      rx_in_crc_ok = 1'b1; rx_in_maint = 1'b0;
      cs_in_valid = 1'b0; cs_in_kind = '0; cs_in_ackid = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_rx_recovery();
      t_rx_disabled();
      t_tx_fill();
      t_tx_recovery();
      t_force();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule